// File: doc/BRIEF.md
# DDS Tuning Word Receiver with Phase Accumulator

This block is the device side of a direct digital synthesizer's load port. A host drives a write clock, an update strobe and an eight-bit data bus. The block collects a 40-bit word from those pins, either one byte per write-clock edge or one bit per edge. The word is one control byte followed by a 32-bit tuning word. It is held in a staging register and reaches the active registers only when the update strobe fires.

The active tuning word is added into a 32-bit phase accumulator on every reference clock. A five-bit phase offset, in steps of 1/32 of a turn (11.25 degrees), is added to the top bits of the accumulator to form the registered phase output. The frequency step is the reference frequency divided by 2^32, about 0.029 Hz at 125 MHz.

A power-down bit forces the output to zero and freezes the accumulator. A control word with its test bit set is refused and raises a flag. The multiplier-enable bit is only stored and shown on a port. The receiver starts in byte mode and switches to bit mode after a strap pattern on the low data pins.

Top module: `dds_word_rx`

## Requirements
- R1: While `rst` is high, at the next clock edge `phase_out`, `out_en`, `serial_mode`, `mult_en` and `test_flag` become 0, the accumulator and all active registers clear, and the receiver returns to byte mode with its pointer at the first slot.
- R2: In byte mode, each `wclk` rising edge captures `din` into the next of five slots: the control byte first, then the tuning word most significant byte first. The control byte holds the phase offset in bits 7:3, power-down in bit 2, the test bit in bit 1 and multiplier enable in bit 0.
- R3: In bit mode, each `wclk` rising edge captures `din[7]`. Forty bits form the word, and the first bit is control bit 7 and the last is tuning bit 0.
- R4: Captured data has no effect on the outputs until a `fqud` rising edge copies the staged word into the active registers.
- R5: When not powered down, the accumulator adds the active tuning word on every clock and wraps modulo 2^32, so consecutive `phase_out` samples differ by the tuning word.
- R6: `phase_out` equals the accumulator plus the phase offset placed in its top five bits (offset << 27).
- R7: With power-down active, `phase_out` is 0, `out_en` is 0 and the accumulator holds its value, so after power-down is cleared the output resumes from the held phase.
- R8: In byte mode, a `wclk` edge at the first slot with `din[2:0]` = 3'b011, followed by a `fqud` edge with `din[2:0]` = 3'b011 and no other `wclk` edge in between, switches to bit mode without a commit. Bit mode then lasts until reset.
- R9: Every `fqud` edge returns the slot pointer to the first slot. Write-clock edges after a full word are ignored.
- R10: A committed word whose test bit (control bit 1) is set leaves the active registers unchanged and sets `test_flag`. The next accepted commit clears the flag.
- R11: `mult_en` shows control bit 0 of the last accepted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wclk | input | 1 | Write clock pin, sampled on clk |
| fqud | input | 1 | Update strobe pin, sampled on clk |
| din | input | 8 | Data bus; din[7] carries serial data, din[2:0] carry the strap |
| phase_out | output | 32 | Registered phase word |
| out_en | output | 1 | High when the output is not powered down |
| serial_mode | output | 1 | High in bit mode |
| mult_en | output | 1 | Stored multiplier enable |
| test_flag | output | 1 | Last commit was refused for its test bit |

## Verification
The assertions assume that `wclk`, `fqud` and `din` are synchronous to `clk`. Each pin level must be held for at least one clock, so that every rising edge is seen exactly once, and `wclk` and `fqud` must never rise in the same cycle. The bench changes every pin on the falling clock edge, holds each strobe high for one full cycle and low for at least one, and issues the write-clock and update pulses one after another. It never overlaps them.

// File: rtl/dds_rx_pkg.sv
package dds_rx_pkg;
  // control byte layout (fixed by the load format)
  localparam int CTRL_W  = 8;
  localparam int OFS_W   = 5;
  localparam int BYTE_W  = 8;
  localparam logic [2:0] SERIAL_STRAP = 3'b011;

  typedef struct packed {
    logic [OFS_W-1:0] ofs;
    logic             pd;
    logic             test;
    logic             mult;
  } ctrl_t;
endpackage

// File: rtl/dds_pin_edge.sv
module dds_pin_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= pin;
  end

  generate
    for (genvar i = 0; i < N; i++) begin : g_edge
      assign rise[i] = pin[i] & ~prev_q[i];
    end
  endgenerate
endmodule

// File: rtl/dds_load_stager.sv
module dds_load_stager
  import dds_rx_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wclk_rise,
  input  logic                   fqud_rise,
  input  logic [BYTE_W-1:0]      din,
  output logic [CTRL_W+ACC_W-1:0] stage_word,
  output logic                   commit,
  output logic                   serial_mode
);
  localparam int WORD_W = CTRL_W + ACC_W;
  localparam int NBYTES = WORD_W / BYTE_W;
  localparam int PTR_W  = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] stage_q;
  logic [PTR_W-1:0]  ptr_q;
  logic              serial_q;
  logic              arm_q;
  logic              strap_seen;
  logic              enter_serial;
  logic              take;

  assign strap_seen   = (din[2:0] == SERIAL_STRAP);
  assign enter_serial = fqud_rise && !serial_q && arm_q && strap_seen;
  assign commit       = fqud_rise && !enter_serial;
  // update strobe wins over a simultaneous write clock
  assign take         = wclk_rise && !fqud_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q  <= '0;
      ptr_q    <= '0;
      serial_q <= 1'b0;
      arm_q    <= 1'b0;
    end else if (fqud_rise) begin
      ptr_q <= '0;
      arm_q <= 1'b0;
      if (enter_serial) serial_q <= 1'b1;
    end else if (take) begin
      arm_q <= (ptr_q == '0) && strap_seen && !serial_q;
      if (serial_q) begin
        if (ptr_q < PTR_W'(WORD_W)) begin
          for (int i = 0; i < WORD_W; i++) begin
            if (ptr_q == PTR_W'(i)) stage_q[WORD_W-1-i] <= din[BYTE_W-1];
          end
          ptr_q <= ptr_q + 1'b1;
        end
      end else begin
        if (ptr_q < PTR_W'(NBYTES)) begin
          for (int b = 0; b < NBYTES; b++) begin
            if (ptr_q == PTR_W'(b)) stage_q[WORD_W-1-BYTE_W*b -: BYTE_W] <= din;
          end
          ptr_q <= ptr_q + 1'b1;
        end
      end
    end
  end

  assign stage_word  = stage_q;
  assign serial_mode = serial_q;

  // R9
  ptr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    fqud_rise |=> (ptr_q == '0));

  // R8
  serial_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    serial_q |=> serial_q);

  // R8
  serial_entry_no_commit_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(serial_q) |-> ($past(fqud_rise) && !$past(commit)));
endmodule

// File: rtl/dds_active_bank.sv
module dds_active_bank
  import dds_rx_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    commit,
  input  logic [CTRL_W+ACC_W-1:0] stage_word,
  output logic [ACC_W-1:0]        ftw,
  output logic [OFS_W-1:0]        ofs,
  output logic                    pd,
  output logic                    mult,
  output logic                    test_flag
);
  ctrl_t            ctrl_in;
  logic [ACC_W-1:0] ftw_in;
  ctrl_t            ctrl_q;
  logic [ACC_W-1:0] ftw_q;
  logic             test_q;

  assign ctrl_in = ctrl_t'(stage_word[CTRL_W+ACC_W-1 -: CTRL_W]);
  assign ftw_in  = stage_word[ACC_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      ftw_q  <= '0;
      test_q <= 1'b0;
    end else if (commit) begin
      if (ctrl_in.test) begin
        test_q <= 1'b1;
      end else begin
        test_q <= 1'b0;
        ctrl_q <= ctrl_in;
        ftw_q  <= ftw_in;
      end
    end
  end

  assign ftw       = ftw_q;
  assign ofs       = ctrl_q.ofs;
  assign pd        = ctrl_q.pd;
  assign mult      = ctrl_q.mult;
  assign test_flag = test_q;

  // R10
  test_word_refused_chk: assert property (@(posedge clk) disable iff (rst)
    (commit && ctrl_in.test) |=> (test_q && $stable(ftw_q) && $stable(ctrl_q)));
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc
  import dds_rx_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] ftw,
  input  logic [OFS_W-1:0] ofs,
  input  logic             pd,
  output logic [ACC_W-1:0] phase_out,
  output logic             out_en
);
  localparam int LOW_W = ACC_W - OFS_W;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] ofs_word;

  assign ofs_word = {ofs, {LOW_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      phase_out <= '0;
      out_en    <= 1'b0;
    end else begin
      if (!pd) acc_q <= acc_q + ftw;
      phase_out <= pd ? '0 : (acc_q + ofs_word);
      out_en    <= !pd;
    end
  end

  // R7
  pd_gates_output_chk: assert property (@(posedge clk) disable iff (rst)
    pd |=> ((phase_out == '0) && !out_en));

  // R7
  pd_freezes_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (pd && $past(pd)) |-> $stable(acc_q));
endmodule

// File: rtl/dds_word_rx.sv
module dds_word_rx
  import dds_rx_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wclk,
  input  logic             fqud,
  input  logic [7:0]       din,
  output logic [ACC_W-1:0] phase_out,
  output logic             out_en,
  output logic             serial_mode,
  output logic             mult_en,
  output logic             test_flag
);
  localparam int WORD_W = CTRL_W + ACC_W;

  logic [1:0]        rise;
  logic [WORD_W-1:0] stage_word;
  logic              commit;
  logic [ACC_W-1:0]  ftw;
  logic [OFS_W-1:0]  ofs;
  logic              pd;

  dds_pin_edge #(.N(2)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .pin  ({fqud, wclk}),
    .rise (rise)
  );

  dds_load_stager #(.ACC_W(ACC_W)) u_stager (
    .clk         (clk),
    .rst         (rst),
    .wclk_rise   (rise[0]),
    .fqud_rise   (rise[1]),
    .din         (din),
    .stage_word  (stage_word),
    .commit      (commit),
    .serial_mode (serial_mode)
  );

  dds_active_bank #(.ACC_W(ACC_W)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .commit     (commit),
    .stage_word (stage_word),
    .ftw        (ftw),
    .ofs        (ofs),
    .pd         (pd),
    .mult       (mult_en),
    .test_flag  (test_flag)
  );

  dds_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk       (clk),
    .rst       (rst),
    .ftw       (ftw),
    .ofs       (ofs),
    .pd        (pd),
    .phase_out (phase_out),
    .out_en    (out_en)
  );
endmodule

// File: tb/sim_dds_word_rx.sv
`timescale 1ns/1ps
module sim_dds_word_rx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wclk = 1'b0;
  logic        fqud = 1'b0;
  logic [7:0]  din = 8'h00;
  logic [31:0] phase_out;
  logic        out_en, serial_mode, mult_en, test_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dds_word_rx u0 (
    .clk(clk), .rst(rst), .wclk(wclk), .fqud(fqud), .din(din),
    .phase_out(phase_out), .out_en(out_en), .serial_mode(serial_mode),
    .mult_en(mult_en), .test_flag(test_flag)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wclk = 1'b0; fqud = 1'b0; din = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_wclk(input logic [7:0] v);
    @(negedge clk);
    din = v; wclk = 1'b1;
    @(negedge clk);
    wclk = 1'b0;
  endtask

  task automatic strobe(input logic [7:0] v);
    @(negedge clk);
    din = v; fqud = 1'b1;
    @(negedge clk);
    fqud = 1'b0;
  endtask

  task automatic send_par(input logic [39:0] w);
    for (int b = 0; b < 5; b++) pulse_wclk(w[39-8*b -: 8]);
  endtask

  task automatic send_ser(input logic [39:0] w);
    for (int i = 0; i < 40; i++) pulse_wclk({w[39-i], 7'b0});
  endtask

  task automatic step(output logic [31:0] d);
    logic [31:0] a;
    repeat (3) @(negedge clk);
    a = phase_out;
    @(negedge clk);
    d = phase_out - a;
  endtask

  // R1
  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 phase_out", phase_out, 0);
    chk("R1 out_en", out_en, 0);
    chk("R1 serial_mode", serial_mode, 0);
    chk("R1 mult_en", mult_en, 0);
    chk("R1 test_flag", test_flag, 0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // R2 R5
  task automatic t_parallel();
    logic [31:0] d;
    do_reset();
    send_par({8'h00, 32'h0123_4567});
    strobe(8'h00);
    step(d);
    chk("R2 step", d, 32'h0123_4567);
    chk("R2 out_en", out_en, 1);
    send_par({8'h00, 32'hC000_0001});
    strobe(8'h00);
    step(d);
    chk("R5 wrap step", d, 32'hC000_0001);
  endtask

  // R4
  task automatic t_staging();
    logic [31:0] d;
    send_par({8'h01, 32'h0000_0777});
    repeat (4) @(negedge clk);
    step(d);
    chk("R4 staged word inactive", d, 32'hC000_0001);
    chk("R4 mult still clear", mult_en, 0);
    strobe(8'h00);
    step(d);
    chk("R4 after update", d, 32'h0000_0777);
  endtask

  // R6
  task automatic t_offset();
    do_reset();
    send_par({5'd13, 3'b000, 32'h0});
    strobe(8'h00);
    repeat (3) @(negedge clk);
    chk("R6 offset 13", phase_out, {5'd13, 27'd0});
    send_par({5'd31, 3'b000, 32'h0});
    strobe(8'h00);
    repeat (3) @(negedge clk);
    chk("R6 offset 31", phase_out, {5'd31, 27'd0});
  endtask

  // R7
  task automatic t_powerdown();
    int guard;
    do_reset();
    send_par({8'b0000_0100, 32'h0000_1000});
    strobe(8'h00);
    repeat (4) @(negedge clk);
    chk("R7 output zero", phase_out, 0);
    chk("R7 out_en low", out_en, 0);
    send_par({8'h00, 32'h0000_1000});
    strobe(8'h00);
    guard = 0;
    while (!out_en && guard < 10) begin
      @(negedge clk);
      guard++;
    end
    chk("R7 resume from held phase", phase_out, 0);
    @(negedge clk);
    chk("R7 first step after resume", phase_out, 32'h0000_1000);
  endtask

  // R10 R11
  task automatic t_testbit();
    logic [31:0] d;
    do_reset();
    send_par({8'h00, 32'h0000_0100});
    strobe(8'h00);
    send_par({8'b1111_1011, 32'h0000_FFFF});
    strobe(8'h00);
    @(negedge clk);
    chk("R10 flag set", test_flag, 1);
    chk("R11 mult unchanged", mult_en, 0);
    step(d);
    chk("R10 tuning unchanged", d, 32'h0000_0100);
    send_par({8'h01, 32'h0000_0200});
    strobe(8'h00);
    @(negedge clk);
    chk("R10 flag cleared", test_flag, 0);
    chk("R11 mult set", mult_en, 1);
  endtask

  // R9
  task automatic t_align();
    logic [31:0] d;
    do_reset();
    pulse_wclk(8'hAA);
    pulse_wclk(8'hBB);
    strobe(8'h00);
    send_par({8'h00, 32'h0000_0800});
    pulse_wclk(8'hFF);
    strobe(8'h00);
    step(d);
    chk("R9 aligned after partial", d, 32'h0000_0800);
    chk("R9 extra byte ignored", test_flag, 0);
  endtask

  // R8 R3 R1
  task automatic t_serial();
    logic [31:0] d;
    do_reset();
    pulse_wclk(8'h03);
    strobe(8'h03);
    @(negedge clk);
    chk("R8 serial entered", serial_mode, 1);
    chk("R8 no commit on entry", test_flag, 0);
    chk("R8 mult untouched", mult_en, 0);
    send_ser({8'h01, 32'h1234_5678});
    strobe(8'h03);
    @(negedge clk);
    chk("R8 stays serial", serial_mode, 1);
    chk("R3 control bit 0", mult_en, 1);
    step(d);
    chk("R3 serial tuning", d, 32'h1234_5678);
    do_reset();
    chk("R1 back to parallel", serial_mode, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_parallel();
    t_staging();
    t_offset();
    t_powerdown();
    t_testbit();
    t_align();
    t_serial();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule